// File: doc/BRIEF.md
# Parallel IO Bank Pin Controller

This block manages one bank of general-purpose pads. For each pin it decides who drives the pad: the block's own GPIO registers, or one of two on-chip peripheral functions (called A and B here). For GPIO-owned pins it holds an output-enable bit and an output-data bit. For every pin it also holds a pull-up enable and an open-drain (multi-drive) bit. The level actually present on the pads can be read back whatever owns each pin.

Software changes per-pin state only through paired write-one-to-set and write-one-to-clear addresses. Each write touches only the pins whose data bit is 1, so no read-modify-write sequence is needed and two agents can never corrupt each other's pins. Each attribute also has a read-only status address. The host port is a plain synchronous bus with a one-cycle read latency. The pad side carries per-pin output value, output enable, pull-up enable and input level. The peripheral A/B drive and enable signals enter as vectors, and the pad levels are returned to the peripherals unchanged.

Top module: `pio_bank_ctrl`

## Requirements
- R1: After reset, every pin is GPIO-owned, output enables and output data are all 0, pull-ups are all enabled, open-drain is off for all pins and peripheral A is selected. As a result, pad_oe is 0 and pad_pu is all ones.
- R2: Writing to byte address 0x00 gives the pins at the 1 bits to GPIO, and writing to 0x04 gives them to a peripheral. Address 0x08 reads the ownership mask, with 1 meaning GPIO. Pins at 0 bits of any set or clear write keep their state.
- R3: Writing to 0x70 selects peripheral A for the pins at the 1 bits, and writing to 0x74 selects peripheral B. Address 0x78 reads the selection, with 1 meaning B.
- R4: Writing to 0x10 enables GPIO output for the pins at the 1 bits, and writing to 0x14 disables it. Address 0x18 reads the output-enable mask.
- R5: Writing to 0x30 sets the output data bits at the 1 bits, and writing to 0x34 clears them. Address 0x38 reads the output data.
- R6: Writing to 0x64 enables the pull-up for the pins at the 1 bits, and writing to 0x60 disables it. Address 0x68 reads the mask. The pad_pu output always equals this mask.
- R7: Writing to 0x50 turns open-drain mode on for the pins at the 1 bits, and writing to 0x54 turns it off. Address 0x58 reads the mask. A pin in open-drain mode never drives high: a driven 0 gives pad_oe=1 with pad_out=0, and a driven 1 gives pad_oe=0.
- R8: On a GPIO-owned pin that is not in open-drain mode, pad_out follows the output data bit and pad_oe follows the output-enable bit. Both change in the cycle after the write.
- R9: On a peripheral-owned pin, the drive value and enable come from per_a_out/per_a_oe when A is selected and from per_b_out/per_b_oe when B is selected. The GPIO output registers have no effect on such a pin.
- R10: Address 0x3C reads the pad input levels of all pins, whatever owns them, after a two-flop synchronizer. A level held stable for two clock edges before the read edge is returned. per_in carries pad_in to the peripherals unchanged.
- R11: Read data appears on bus_rdata in the cycle after the read request and is held until the next read. Reads of unmapped addresses return 0. Writes to status or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pad pull-up enables |
| per_a_out | input | NPINS | Peripheral A drive values |
| per_a_oe | input | NPINS | Peripheral A drive enables |
| per_b_out | input | NPINS | Peripheral B drive values |
| per_b_oe | input | NPINS | Peripheral B drive enables |
| per_in | output | NPINS | Pad levels passed to the peripherals |

## Verification
The bench builds the block with its default parameters: 32 pins and an 8-bit byte address. With 32 pins, a single full-width random mask mixes all owner, select, open-drain and enable combinations at once in every cycle. The 8-bit address space leaves room for unmapped and status addresses next to the writable ones, so stray writes and zero-returning reads are exercised. Mapped addresses are drawn together with these stray ones.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int NATTR   = 6;
  localparam int A_OWN   = 0;
  localparam int A_OE    = 1;
  localparam int A_OD    = 2;
  localparam int A_MD    = 3;
  localparam int A_PU    = 4;
  localparam int A_SEL   = 5;

  localparam logic [7:0] OFS_PIN_LVL = 8'h3C;

  function automatic logic [7:0] set_ofs(input int idx);
    case (idx)
      A_OWN:   return 8'h00;
      A_OE:    return 8'h10;
      A_OD:    return 8'h30;
      A_MD:    return 8'h50;
      A_PU:    return 8'h64;
      default: return 8'h74;
    endcase
  endfunction

  function automatic logic [7:0] clr_ofs(input int idx);
    case (idx)
      A_OWN:   return 8'h04;
      A_OE:    return 8'h14;
      A_OD:    return 8'h34;
      A_MD:    return 8'h54;
      A_PU:    return 8'h60;
      default: return 8'h70;
    endcase
  endfunction

  function automatic logic [7:0] sts_ofs(input int idx);
    case (idx)
      A_OWN:   return 8'h08;
      A_OE:    return 8'h18;
      A_OD:    return 8'h38;
      A_MD:    return 8'h58;
      A_PU:    return 8'h68;
      default: return 8'h78;
    endcase
  endfunction

  function automatic logic rst_ones(input int idx);
    return (idx == A_OWN) || (idx == A_PU);
  endfunction

  function automatic logic is_readable(input logic [7:0] a);
    logic hit;
    hit = (a == OFS_PIN_LVL);
    for (int i = 0; i < NATTR; i++) begin
      if (a == sts_ofs(i)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pio_w1_reg.sv
module pio_w1_reg #(
  parameter int   W       = 32,
  parameter logic RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         upd_en;

  assign upd_en = |(set_i | clr_i);

  always_comb begin
    val_d = val_q;
    if (upd_en) val_d = (val_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= {W{RST_ONE}};
    else if (upd_en) val_q <= val_d;
  end

  assign q_o = val_q;

endmodule

// File: rtl/pio_bus_if.sv
module pio_bus_if
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NPINS-1:0]             wdata_i,
  input  logic [NATTR-1:0][NPINS-1:0]  sts_i,
  input  logic [NPINS-1:0]             lvl_i,
  output logic [NATTR-1:0][NPINS-1:0]  set_o,
  output logic [NATTR-1:0][NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]             rdata_o
);

  logic              wr_en;
  logic              rd_en;
  logic [7:0]        a8;
  logic [NPINS-1:0]  rd_mux;
  logic [NPINS-1:0]  rd_q;
  logic [NPINS-1:0]  rd_d;

  assign wr_en = sel_i & we_i;
  assign rd_en = sel_i & ~we_i;
  assign a8    = 8'(addr_i);

  for (genvar g = 0; g < NATTR; g++) begin : g_dec
    assign set_o[g] = (wr_en && a8 == set_ofs(g)) ? wdata_i : '0;
    assign clr_o[g] = (wr_en && a8 == clr_ofs(g)) ? wdata_i : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NATTR; i++) begin
      if (a8 == sts_ofs(i)) rd_mux = sts_i[i];
    end
    if (a8 == OFS_PIN_LVL) rd_mux = lvl_i;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own_i,
  input  logic [NPINS-1:0] selb_i,
  input  logic [NPINS-1:0] oe_i,
  input  logic [NPINS-1:0] od_i,
  input  logic [NPINS-1:0] md_i,
  input  logic [NPINS-1:0] a_out_i,
  input  logic [NPINS-1:0] a_oe_i,
  input  logic [NPINS-1:0] b_out_i,
  input  logic [NPINS-1:0] b_oe_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic per_v;
    logic per_e;
    logic src_v;
    logic src_e;
    always_comb begin
      per_v = selb_i[p] ? b_out_i[p] : a_out_i[p];
      per_e = selb_i[p] ? b_oe_i[p]  : a_oe_i[p];
      src_v = own_i[p]  ? od_i[p]    : per_v;
      src_e = own_i[p]  ? oe_i[p]    : per_e;
      pad_oe_o[p]  = src_e & ~(md_i[p] & src_v);
      pad_out_o[p] = src_v & ~md_i[p];
    end
  end

endmodule

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  input  logic [NPINS-1:0]  per_a_out,
  input  logic [NPINS-1:0]  per_a_oe,
  input  logic [NPINS-1:0]  per_b_out,
  input  logic [NPINS-1:0]  per_b_oe,
  output logic [NPINS-1:0]  per_in
);

  logic                        rst_sync_n;
  logic [NATTR-1:0][NPINS-1:0] attr_set;
  logic [NATTR-1:0][NPINS-1:0] attr_clr;
  logic [NATTR-1:0][NPINS-1:0] attr_q;
  logic [NPINS-1:0]            lvl_sync;
  logic [NPINS-1:0]            own_q;
  logic [NPINS-1:0]            oe_q;
  logic [NPINS-1:0]            od_q;
  logic [NPINS-1:0]            md_q;
  logic [NPINS-1:0]            pu_q;
  logic [NPINS-1:0]            selb_q;

  pio_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  pio_sync #(.W(NPINS), .STAGES(2)) u_lvl_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pad_in),
    .q_o   (lvl_sync)
  );

  pio_bus_if #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_i   (bus_sel),
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .sts_i   (attr_q),
    .lvl_i   (lvl_sync),
    .set_o   (attr_set),
    .clr_o   (attr_clr),
    .rdata_o (bus_rdata)
  );

  for (genvar g = 0; g < NATTR; g++) begin : g_attr
    pio_w1_reg #(.W(NPINS), .RST_ONE(rst_ones(g))) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (attr_set[g]),
      .clr_i (attr_clr[g]),
      .q_o   (attr_q[g])
    );
  end

  assign own_q  = attr_q[A_OWN];
  assign oe_q   = attr_q[A_OE];
  assign od_q   = attr_q[A_OD];
  assign md_q   = attr_q[A_MD];
  assign pu_q   = attr_q[A_PU];
  assign selb_q = attr_q[A_SEL];

  pio_pad_mux #(.NPINS(NPINS)) u_mux (
    .own_i     (own_q),
    .selb_i    (selb_q),
    .oe_i      (oe_q),
    .od_i      (od_q),
    .md_i      (md_q),
    .a_out_i   (per_a_out),
    .a_oe_i    (per_a_oe),
    .b_out_i   (per_b_out),
    .b_oe_i    (per_b_oe),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  assign pad_pu = pu_q;
  assign per_in = pad_in;

endmodule

// File: rtl/pio_bank_ctrl_chk.sv
module pio_bank_ctrl_chk
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  own_q,
  input logic [NPINS-1:0]  oe_q,
  input logic [NPINS-1:0]  od_q,
  input logic [NPINS-1:0]  md_q
);

  logic [2:0] warm_cnt;
  logic       warm;
  logic [7:0] a8;

  assign a8   = 8'(bus_addr);
  assign warm = (warm_cnt == 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     warm_cnt <= '0;
    else if (!warm) warm_cnt <= warm_cnt + 3'd1;
  end

  // R4
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (bus_sel && bus_we && a8 == 8'h10) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  od_clr_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (bus_sel && bus_we && a8 == 8'h34) |=> ((od_q & $past(bus_wdata)) == '0));

  // R2
  own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    !(bus_sel && bus_we) |=> $stable(own_q));

  // R7
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ((pad_oe & md_q & own_q & od_q) == '0));

  // R10
  lvl_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (bus_sel && !bus_we && a8 == OFS_PIN_LVL) |=> (bus_rdata == $past(pad_in, 3)));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (bus_sel && !bus_we && !is_readable(a8)) |=> (bus_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

bind pio_bank_ctrl pio_bank_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .own_q     (own_q),
  .oe_q      (oe_q),
  .od_q      (od_q),
  .md_q      (md_q)
);

// File: tb/test_pio_bank_ctrl.sv
module test_pio_bank_ctrl;

  localparam int NP = 32;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [NP-1:0] bus_wdata;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_pu;
  logic [NP-1:0] per_a_out;
  logic [NP-1:0] per_a_oe;
  logic [NP-1:0] per_b_out;
  logic [NP-1:0] per_b_oe;
  logic [NP-1:0] per_in;

  int n_chk;
  int n_err;

  logic [NP-1:0] m_own, m_oe, m_od, m_md, m_pu, m_selb;

  pio_bank_ctrl #(.NPINS(NP), .ADDR_W(AW)) i_pio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .per_a_out(per_a_out), .per_a_oe(per_a_oe), .per_b_out(per_b_out),
    .per_b_oe(per_b_oe), .per_in(per_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [7:0] a, input logic [NP-1:0] d);
    case (a)
      8'h00: m_own  = m_own | d;
      8'h04: m_own  = m_own & ~d;
      8'h10: m_oe   = m_oe | d;
      8'h14: m_oe   = m_oe & ~d;
      8'h30: m_od   = m_od | d;
      8'h34: m_od   = m_od & ~d;
      8'h50: m_md   = m_md | d;
      8'h54: m_md   = m_md & ~d;
      8'h64: m_pu   = m_pu | d;
      8'h60: m_pu   = m_pu & ~d;
      8'h74: m_selb = m_selb | d;
      8'h70: m_selb = m_selb & ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [NP-1:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h08: return m_own;
      8'h18: return m_oe;
      8'h38: return m_od;
      8'h58: return m_md;
      8'h68: return m_pu;
      8'h78: return m_selb;
      8'h3C: return pad_in;
      default: return '0;
    endcase
  endfunction

  function automatic logic [NP-1:0] src_val();
    return (m_own & m_od) | (~m_own & ~m_selb & per_a_out) | (~m_own & m_selb & per_b_out);
  endfunction

  function automatic logic [NP-1:0] src_en();
    return (m_own & m_oe) | (~m_own & ~m_selb & per_a_oe) | (~m_own & m_selb & per_b_oe);
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    return src_en() & ~(m_md & src_val());
  endfunction

  function automatic logic [NP-1:0] exp_out();
    return src_val() & ~m_md;
  endfunction

  function automatic logic [7:0] pick_addr(input int k);
    case (k)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h10;  3: return 8'h14;
      4: return 8'h30;  5: return 8'h34;  6: return 8'h50;  7: return 8'h54;
      8: return 8'h60;  9: return 8'h64; 10: return 8'h70; 11: return 8'h74;
      12: return 8'h08; 13: return 8'h3C; 14: return 8'h0C; default: return 8'h80;
    endcase
  endfunction

  function automatic logic [7:0] pick_rd(input int k);
    case (k)
      0: return 8'h08; 1: return 8'h18; 2: return 8'h38; 3: return 8'h58;
      4: return 8'h68; 5: return 8'h78; 6: return 8'h3C; default: return 8'h44;
    endcase
  endfunction

  function automatic string rd_req(input logic [7:0] a);
    case (a)
      8'h08: return "R2";  8'h18: return "R4";  8'h38: return "R5";
      8'h58: return "R7";  8'h68: return "R6";  8'h78: return "R3";
      8'h3C: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_pads(input string req);
    chk(req, pad_oe, exp_oe());
    chk(req, pad_out, exp_out());
    chk("R6", pad_pu, m_pu);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NP-1:0] rv;
    int unused_seed;
    unused_seed = $urandom(32'h1A2B);
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = 32'hA5A5_0F0F;
    per_a_out = 32'hFFFF_0000; per_a_oe = 32'hFFFF_FFFF;
    per_b_out = 32'h00FF_00FF; per_b_oe = 32'hFFFF_FFFF;
    m_own = '1; m_oe = '0; m_od = '0; m_md = '0; m_pu = '1; m_selb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 reset state
    chk("R1", pad_oe, '0);
    chk("R1", pad_pu, '1);
    for (int i = 0; i < 6; i++) begin
      do_rd(pick_rd(i), rv);
      chk("R1", rv, exp_rd(pick_rd(i)));
    end
    do_rd(8'h3C, rv);
    chk("R10", rv, 32'hA5A5_0F0F);
    chk("R10", per_in, pad_in);

    // R2 zero mask changes nothing
    do_wr(8'h04, '0);
    do_rd(8'h08, rv);
    chk("R2", rv, '1);

    // R8 GPIO output
    do_wr(8'h30, 32'h0000_00F0);
    do_wr(8'h10, 32'h0000_00FF);
    chk_pads("R8");
    chk("R8", pad_oe, 32'h0000_00FF);
    chk("R8", pad_out, 32'h0000_00F0);

    // R7 open drain: high released, low driven
    do_wr(8'h50, 32'h0000_000F << 2);
    chk("R7", pad_oe, 32'h0000_00CF);
    chk("R7", pad_out, 32'h0000_00C0);

    // R9 peripheral ownership, A then B; GPIO regs ignored
    do_wr(8'h54, '1);
    do_wr(8'h04, 32'hFFFF_0000);
    chk("R9", pad_out, 32'h0000_00F0 | (32'hFFFF_0000 & per_a_out));
    do_wr(8'h74, 32'hFF00_0000);
    chk("R9", pad_out, exp_out());
    chk("R9", pad_out[31:24], per_b_out[31:24]);
    do_wr(8'h30, 32'hFFFF_0000);
    chk("R9", pad_out[31:16], {per_b_out[31:24], per_a_out[23:16]});
    do_rd(8'h78, rv);
    chk("R3", rv, 32'hFF00_0000);

    // R11 writes to status / unmapped addresses ignored, unmapped read 0
    do_wr(8'h08, 32'h0000_FFFF);
    do_wr(8'h0C, '1);
    do_wr(8'h7C, '1);
    do_rd(8'h08, rv);
    chk("R11", rv, 32'h0000_FFFF);
    chk_pads("R11");
    do_rd(8'h0C, rv);
    chk("R11", rv, '0);
    @(negedge clk);
    chk("R11", bus_rdata, '0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [7:0] wa;
      logic [7:0] ra;
      logic [NP-1:0] wd;
      @(negedge clk);
      pad_in    = $urandom;
      per_a_out = $urandom; per_a_oe = $urandom;
      per_b_out = $urandom; per_b_oe = $urandom;
      wa = pick_addr($urandom % 16);
      wd = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      do_wr(wa, wd);
      chk_pads((m_own == '1) ? "R8" : "R9");
      ra = pick_rd($urandom % 8);
      do_rd(ra, rv);
      chk(rd_req(ra), rv, exp_rd(ra));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule